// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Accumulator Core

This block is a small sequencer that runs a handful of instructions from an 8-bit accumulator instruction set. It reaches a 64 KB byte-wide synchronous memory through one port with a shared address. Read data returns one cycle after the address is presented. A write completes in the cycle in which the write enable is high. The core holds an accumulator, two index registers (X and Y), an 8-bit status byte and a 16-bit program counter.

After a synchronous reset, the core reads a two-byte start address from a fixed vector location, stored low byte first. It then loops through four steps: fetch an opcode, decode it, fetch any operand bytes, and execute. The supported instructions are:
- load accumulator, in immediate, zero-page and absolute forms;
- store accumulator, in zero-page and zero-page-indexed-by-X forms;
- copy the accumulator to X;
- increment X;
- stop.

Any other opcode also stops the core and raises a trap output. The register and status outputs let an enclosing system, or a bench, see the architectural state.

Top module: `acc_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `acc_a`, `idx_x`, `idx_y`, `status_flags`, `halted` and `illegal_op` are all zero. The core then reads address 0xFFFC, then 0xFFFD, and starts fetching at the address {byte at 0xFFFD, byte at 0xFFFC}.
- R2: Read data is taken one cycle after its address. A store raises `mem_we` for exactly one cycle, with `mem_wdata` equal to the accumulator.
- R3: Opcode 0xA9 loads the byte that follows the opcode into the accumulator. Execution then continues two bytes after the opcode.
- R4: Opcode 0xA5 loads the byte at address 0x00nn, where nn is the operand byte. Execution continues two bytes after the opcode.
- R5: Opcode 0xAD loads the byte at the 16-bit address formed by the next two bytes, low byte first. Execution continues three bytes after the opcode.
- R6: Opcode 0x85 writes the accumulator to 0x00nn and leaves `status_flags` unchanged.
- R7: Opcode 0x95 writes the accumulator to 0x00((nn + X) mod 256), so the address stays inside the zero page.
- R8: Opcode 0xAA copies the accumulator into X.
- R9: Opcode 0xE8 increments X modulo 256, so 0xFF becomes 0x00 with the zero flag set.
- R10: Loads, 0xAA and 0xE8 set status bit 1 (zero) exactly when the result byte is 0, and copy result bit 7 into status bit 7 (negative). The other six status bits never change.
- R11: Opcode 0x00 raises `halted` with `illegal_op` low. `halted` stays high until reset, and no memory write happens while it is high.
- R12: Any opcode other than 0xA9, 0xA5, 0xAD, 0x85, 0x95, 0xAA, 0xE8 and 0x00 raises both `halted` and `illegal_op`. Both stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory address for reads and writes |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |
| halted | output | 1 | Core has stopped; sticky until reset |
| illegal_op | output | 1 | Stop was caused by an unknown opcode |
| acc_a | output | 8 | Accumulator |
| idx_x | output | 8 | X index register |
| idx_y | output | 8 | Y index register |
| status_flags | output | 8 | Status byte; bit 1 zero, bit 7 negative |

## Verification
Some properties are checked on every cycle:
- the stop output is sticky, and a trap always implies a stop;
- no write happens after a stop, and writes last one cycle;
- a store never disturbs the status byte, and the six unused status bits never move;
- the vector fetch order right after reset is fixed.

The values themselves can only be shown by the bench's programs:
- the loaded values and the effective addresses, including the zero-page wrap on indexed stores;
- the little-endian vector and absolute operands;
- the flag results, and the wrap of X from 0xFF to 0x00.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] OPC_LDA_IMM = 8'hA9;
  localparam logic [7:0] OPC_LDA_ZP  = 8'hA5;
  localparam logic [7:0] OPC_LDA_ABS = 8'hAD;
  localparam logic [7:0] OPC_STA_ZP  = 8'h85;
  localparam logic [7:0] OPC_STA_ZPX = 8'h95;
  localparam logic [7:0] OPC_TAX     = 8'hAA;
  localparam logic [7:0] OPC_INX     = 8'hE8;
  localparam logic [7:0] OPC_STOP    = 8'h00;

  typedef enum logic [3:0] {
    ST_VEC_LO, ST_VEC_HI, ST_VEC_SET, ST_FETCH, ST_DECODE,
    ST_OPND, ST_OPND2, ST_MEM, ST_LOAD, ST_HALT
  } state_t;

  typedef enum logic [3:0] {
    K_LDA_IMM, K_LDA_ZP, K_LDA_ABS, K_STA_ZP, K_STA_ZPX,
    K_TAX, K_INX, K_STOP, K_BAD
  } kind_t;

  function automatic logic kind_has_operand(kind_t k);
    return (k == K_LDA_IMM) || (k == K_LDA_ZP) || (k == K_LDA_ABS) ||
           (k == K_STA_ZP) || (k == K_STA_ZPX);
  endfunction

  function automatic logic kind_is_store(kind_t k);
    return (k == K_STA_ZP) || (k == K_STA_ZPX);
  endfunction

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output kind_t             kind
);
  always_comb begin
    unique case (opcode)
      OPC_LDA_IMM: kind = K_LDA_IMM;
      OPC_LDA_ZP:  kind = K_LDA_ZP;
      OPC_LDA_ABS: kind = K_LDA_ABS;
      OPC_STA_ZP:  kind = K_STA_ZP;
      OPC_STA_ZPX: kind = K_STA_ZPX;
      OPC_TAX:     kind = K_TAX;
      OPC_INX:     kind = K_INX;
      OPC_STOP:    kind = K_STOP;
      default:     kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/acc_core_zn.sv
module acc_core_zn #(
  parameter int DATA_W = 8,
  parameter int ZF_BIT = 1,
  parameter int NF_BIT = 7
) (
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] status_out
);
  always_comb begin
    status_out         = status_in;
    status_out[ZF_BIT] = (result == '0);
    status_out[NF_BIT] = result[DATA_W-1];
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC,
  parameter int              ZF_BIT   = 1,
  parameter int              NF_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              halted,
  output logic              illegal_op,
  output logic [BYTE_W-1:0] acc_a,
  output logic [BYTE_W-1:0] idx_x,
  output logic [BYTE_W-1:0] idx_y,
  output logic [BYTE_W-1:0] status_flags
);
  localparam int HI_W = ADDR_W - BYTE_W;

  state_t            state;
  kind_t             kind_q, dec_kind;
  logic [ADDR_W-1:0] pc, ea;
  logic [BYTE_W-1:0] a_q, x_q, y_q, st_q;
  logic              halt_q, bad_q;
  logic [BYTE_W-1:0] zn_src, zn_out;

  acc_core_decode u_dec (
    .opcode (mem_rdata),
    .kind   (dec_kind)
  );

  // Flag source: register transfers in decode, memory data otherwise
  always_comb begin
    if (state == ST_DECODE)
      zn_src = (dec_kind == K_TAX) ? a_q : x_q + 8'd1;
    else
      zn_src = mem_rdata;
  end

  acc_core_zn #(.DATA_W(BYTE_W), .ZF_BIT(ZF_BIT), .NF_BIT(NF_BIT)) u_zn (
    .result     (zn_src),
    .status_in  (st_q),
    .status_out (zn_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_VEC_LO;
      kind_q <= K_STOP;
      pc     <= '0;
      ea     <= '0;
      a_q    <= '0;
      x_q    <= '0;
      y_q    <= '0;
      st_q   <= '0;
      halt_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_VEC_LO: state <= ST_VEC_HI;
        ST_VEC_HI: begin
          ea[BYTE_W-1:0] <= mem_rdata;
          state          <= ST_VEC_SET;
        end
        ST_VEC_SET: begin
          pc    <= {mem_rdata, ea[BYTE_W-1:0]};
          state <= ST_FETCH;
        end
        ST_FETCH: begin
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          kind_q <= dec_kind;
          if (kind_has_operand(dec_kind)) begin
            pc    <= pc + 1'b1;
            state <= ST_OPND;
          end else begin
            unique case (dec_kind)
              K_TAX: begin
                x_q   <= a_q;
                st_q  <= zn_out;
                state <= ST_FETCH;
              end
              K_INX: begin
                x_q   <= x_q + 8'd1;
                st_q  <= zn_out;
                state <= ST_FETCH;
              end
              K_STOP: begin
                halt_q <= 1'b1;
                state  <= ST_HALT;
              end
              default: begin
                halt_q <= 1'b1;
                bad_q  <= 1'b1;
                state  <= ST_HALT;
              end
            endcase
          end
        end
        ST_OPND: begin
          unique case (kind_q)
            K_LDA_IMM: begin
              a_q   <= mem_rdata;
              st_q  <= zn_out;
              state <= ST_FETCH;
            end
            K_STA_ZPX: begin
              ea    <= {{HI_W{1'b0}}, mem_rdata + x_q};
              state <= ST_MEM;
            end
            K_LDA_ABS: begin
              ea[BYTE_W-1:0] <= mem_rdata;
              pc             <= pc + 1'b1;
              state          <= ST_OPND2;
            end
            default: begin
              ea    <= {{HI_W{1'b0}}, mem_rdata};
              state <= ST_MEM;
            end
          endcase
        end
        ST_OPND2: begin
          ea[ADDR_W-1:BYTE_W] <= mem_rdata[HI_W-1:0];
          state               <= ST_MEM;
        end
        ST_MEM: state <= kind_is_store(kind_q) ? ST_FETCH : ST_LOAD;
        ST_LOAD: begin
          a_q   <= mem_rdata;
          st_q  <= zn_out;
          state <= ST_FETCH;
        end
        default: state <= ST_HALT;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_VEC_LO: mem_addr = VEC_ADDR;
      ST_VEC_HI: mem_addr = VEC_ADDR + 1'b1;
      ST_MEM:    mem_addr = ea;
      default:   mem_addr = pc;
    endcase
  end

  assign mem_we       = (state == ST_MEM) && kind_is_store(kind_q);
  assign mem_wdata    = a_q;
  assign halted       = halt_q;
  assign illegal_op   = bad_q;
  assign acc_a        = a_q;
  assign idx_x        = x_q;
  assign idx_y        = y_q;
  assign status_flags = st_q;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              halted,
  input logic              illegal_op,
  input logic [7:0]        status_flags
);
  // R11: stop is sticky until reset
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  // R11: no write after the core stops
  a_r11_no_write_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we);
  // R12: a trap always comes with a stop
  a_r12_trap_halts: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> halted);
  // R2: a write lasts exactly one cycle
  a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  // R6: a store leaves the status byte alone
  a_r6_store_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> $stable(status_flags));
  // R10: the six unused status bits never move
  a_r10_spare_bits: assert property (@(posedge clk) disable iff (rst)
    $stable(status_flags & 8'h7D));
  // R1: the first address after reset is the low vector byte
  a_r1_vector_first: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_addr == 16'hFFFC));
endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/acc_core_tb.sv
module acc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        halted, illegal_op;
  logic [7:0]  acc_a, idx_x, idx_y, status_flags;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  acc_core u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted),
    .illegal_op(illegal_op), .acc_a(acc_a), .idx_x(idx_x), .idx_y(idx_y),
    .status_flags(status_flags)
  );

  // Sparse memory model: one-cycle read latency, single-cycle write
  logic [7:0] mem [int];
  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Scoreboard of expected writes
  typedef struct packed { logic [15:0] addr; logic [7:0] data; } wr_t;
  wr_t exp_q[$];

  task automatic expect_wr(input logic [15:0] addr, input logic [7:0] data);
    exp_q.push_back({addr, data});
  endtask

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected write addr", mem_addr, 16'hFFFF);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        check("R2/R6/R7 write addr", mem_addr, w.addr);
        check("R2 write data", {8'h00, mem_wdata}, {8'h00, w.data});
      end
    end
  end

  logic [15:0] wp;
  task automatic emit(input logic [7:0] b);
    mem[int'(wp)] = b;
    wp = wp + 16'd1;
  endtask

  task automatic set_vector(input logic [15:0] v);
    mem.delete();
    mem[32'hFFFC] = v[7:0];
    mem[32'hFFFD] = v[15:8];
    wp = v;
  endtask

  task automatic start_and_wait();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 acc reset", {8'h00, acc_a}, 16'h0000);
    check("R1 x/y reset", {idx_x, idx_y}, 16'h0000);
    check("R1 status reset", {8'h00, status_flags}, 16'h0000);
    check("R1 halt/trap reset", {14'h0, halted, illegal_op}, 16'h0000);
    check("R1 first vector read", mem_addr, 16'hFFFC);
    @(negedge clk);
    check("R1 second vector read", mem_addr, 16'hFFFD);
    for (int i = 0; i < 400 && !halted; i++) @(negedge clk);
    check("R11 core stopped", {15'h0, halted}, 16'h0001);
    check("R2 all writes seen", 16'(exp_q.size()), 16'h0000);
    exp_q.delete();
  endtask

  initial begin
    wait (checks < 0);
  end

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R3, R10: immediate non-zero load, then stop
    set_vector(16'h8000);
    emit(8'hA9); emit(8'h05); emit(8'h00);
    start_and_wait();
    check("R3 lda imm value", {8'h00, acc_a}, 16'h0005);
    check("R10 flags clear", {8'h00, status_flags}, 16'h0000);
    check("R11 stop is not a trap", {15'h0, illegal_op}, 16'h0000);

    // R10: zero result sets bit 1
    set_vector(16'h8000);
    emit(8'hA9); emit(8'h00); emit(8'h00);
    start_and_wait();
    check("R10 zero flag", {8'h00, status_flags}, 16'h0002);

    // R8, R9: copy to X then increment
    set_vector(16'h8000);
    emit(8'hA9); emit(8'hC0); emit(8'hAA); emit(8'hE8); emit(8'h00);
    start_and_wait();
    check("R8/R9 x after tax+inx", {8'h00, idx_x}, 16'h00C1);
    check("R10 negative flag", {8'h00, status_flags}, 16'h0080);

    // R9: wrap through 0xFF
    set_vector(16'h8000);
    emit(8'hA9); emit(8'hFF); emit(8'hAA); emit(8'hE8); emit(8'hE8); emit(8'h00);
    start_and_wait();
    check("R9 x wraps", {8'h00, idx_x}, 16'h0001);
    check("R9 flags after wrap", {8'h00, status_flags}, 16'h0000);

    // R9: 0xFF -> 0x00 sets zero
    set_vector(16'h8000);
    emit(8'hA9); emit(8'hFF); emit(8'hAA); emit(8'hE8); emit(8'h00);
    start_and_wait();
    check("R9 x to zero", {8'h00, idx_x}, 16'h0000);
    check("R9 zero flag on wrap", {8'h00, status_flags}, 16'h0002);

    // R1, R4, R5, R6, R7: odd vector, memory forms, zero-page wrap
    set_vector(16'h1234);
    mem[32'h0010] = 8'h80;
    mem[32'h3000] = 8'h00;
    emit(8'hA5); emit(8'h10);
    emit(8'h85); emit(8'h20);
    emit(8'hAD); emit(8'h00); emit(8'h30);
    emit(8'hA9); emit(8'h42);
    emit(8'hAA);
    emit(8'h95); emit(8'hF0);
    emit(8'h00);
    expect_wr(16'h0020, 8'h80);
    expect_wr(16'h0032, 8'h42);
    start_and_wait();
    check("R4/R6 zp store landed", {8'h00, mem[32'h0020]}, 16'h0080);
    check("R5/R3 final acc", {8'h00, acc_a}, 16'h0042);
    check("R7 zpx store wrapped", {8'h00, mem[32'h0032]}, 16'h0042);
    check("R1 y stays clear", {8'h00, idx_y}, 16'h0000);

    // R5: absolute load of zero sets Z
    set_vector(16'h8000);
    mem[32'h3000] = 8'h00;
    emit(8'hA9); emit(8'h77); emit(8'hAD); emit(8'h00); emit(8'h30); emit(8'h00);
    start_and_wait();
    check("R5 abs load value", {8'h00, acc_a}, 16'h0000);
    check("R5 abs load zero flag", {8'h00, status_flags}, 16'h0002);

    // R6: store keeps Z set
    set_vector(16'h8000);
    emit(8'hA9); emit(8'h00); emit(8'h85); emit(8'h40); emit(8'h00);
    expect_wr(16'h0040, 8'h00);
    start_and_wait();
    check("R6 flags after store", {8'h00, status_flags}, 16'h0002);

    // R12: unknown opcode traps; R11 sticky with no writes
    set_vector(16'h8000);
    emit(8'hA9); emit(8'h33); emit(8'h02); emit(8'h85); emit(8'h50); emit(8'h00);
    start_and_wait();
    check("R12 trap raised", {15'h0, illegal_op}, 16'h0001);
    check("R12 acc before trap", {8'h00, acc_a}, 16'h0033);
    repeat (20) @(negedge clk);
    check("R11/R12 still stopped", {14'h0, halted, illegal_op}, 16'h0003);
    check("R11 no write after stop", {15'h0, mem.exists(32'h0050)}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule